// File: doc/BRIEF.md
# Shared Command FIFO with Watermark Alerts

This block is a single byte-wide buffer of 64 entries that carries data in both directions between a host processor and a command engine. The host fills it with arguments or transmit data and drains received data from it; the engine pushes and pops through its own port. A single buffer serves both directions, so a 4-bit command code from the sequencer decides, one access at a time, whether a host write or host read is accepted or silently dropped.

A small state machine tracks the fill condition in three states: `FS_EMPTY`, `FS_PARTIAL` and `FS_FULL`. Its transitions are: first push (`FS_EMPTY` to `FS_PARTIAL`), last pop (`FS_PARTIAL` to `FS_EMPTY`), filling push (`FS_PARTIAL` to `FS_FULL`), draining pop (`FS_FULL` to `FS_PARTIAL`) and flush (any state to `FS_EMPTY`). A push and a pop in the same cycle keep the state. The output process of the machine registers the fill count and three status flags: a high alert from the remaining free space, a low alert from the stored count, and a sticky overflow flag. The interrupt line is the maskable OR of the two alerts.

Top module: `cmd_shared_fifo`

## Requirements
- R1: The buffer keeps up to 64 bytes in first-in first-out order, and `fill_len` (7 bits) reports the stored count from 0 to 64.
- R2: A cycle with `flush` high empties the buffer, so `fill_len` is 0 after that edge and the old bytes can no longer be read. Flush wins over any read or write in the same cycle.
- R3: A write while `fill_len` is 64 is discarded, leaves the stored bytes unchanged and sets `ovfl`. `ovfl` then stays high until a flush clears it.
- R4: `hi_alert` is high exactly when 64 minus the stored count is at most `water_level`. It is registered and changes at the same edge as `fill_len`, and it uses the `water_level` value seen at that edge.
- R5: `lo_alert` is high exactly when the stored count is at most `water_level`, with the same timing as R4.
- R6: `irq` is high when (`lo_irq_en` and `lo_alert`) or (`hi_irq_en` and `hi_alert`), with no added delay.
- R7: Host writes are accepted only in transmit (code 2) and transceive (code 4). Host reads are accepted only in receive (code 3) and transceive (code 4). Start-up (code 0) and idle (code 1) refuse both. A refused access leaves `fill_len` and `host_rdata` unchanged.
- R8: The argument-preparation commands accept host writes and refuse host reads. These are key load (code 5), first authentication step (code 6), configuration load (code 7) and checksum calculation (code 8). Codes 9 to 15 refuse both.
- R9: A push and a pop in the same cycle leave `fill_len` unchanged. A read while empty returns 0x00 and moves no pointer.
- R10: The engine port takes priority. A host write in the same cycle as an engine write is discarded. A host read in the same cycle as an engine read is discarded, and `host_rdata` holds its value.
- R11: After reset, `fill_len` is 0, `lo_alert` is 1, `hi_alert` and `ovfl` are 0, and both read data outputs are 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd | input | 4 | Code of the command now running |
| host_wr | input | 1 | Host write strobe, one byte per cycle |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 8 | Byte returned by the last accepted host read |
| eng_wr | input | 1 | Engine write strobe |
| eng_wdata | input | 8 | Engine write byte |
| eng_rd | input | 1 | Engine read strobe |
| eng_rdata | output | 8 | Byte returned by the last engine read |
| flush | input | 1 | Empties the buffer and clears overflow |
| water_level | input | 6 | Alert threshold |
| lo_irq_en | input | 1 | Lets the low alert drive irq |
| hi_irq_en | input | 1 | Lets the high alert drive irq |
| fill_len | output | 7 | Stored byte count |
| hi_alert | output | 1 | Free space is at most the threshold |
| lo_alert | output | 1 | Stored count is at most the threshold |
| ovfl | output | 1 | Sticky overflow warning |
| irq | output | 1 | Masked alert interrupt |

## Verification
The alert properties compare each flag with the `water_level` value from the previous edge. This lets the threshold change in any cycle, and the bench changes it freely between accesses. The push-and-pop property only claims a stable count when the buffer is neither full nor empty. The bench drives the full and empty edges in separate scenarios. All stimulus changes one time unit after a rising edge, so every property sees inputs that are settled for a whole cycle.

// File: rtl/csf_pkg.sv
package csf_pkg;

    localparam logic [3:0] CMD_STARTUP    = 4'd0;
    localparam logic [3:0] CMD_IDLE       = 4'd1;
    localparam logic [3:0] CMD_TRANSMIT   = 4'd2;
    localparam logic [3:0] CMD_RECEIVE    = 4'd3;
    localparam logic [3:0] CMD_TRANSCEIVE = 4'd4;
    localparam logic [3:0] CMD_KEY_LOAD   = 4'd5;
    localparam logic [3:0] CMD_AUTH_STEP1 = 4'd6;
    localparam logic [3:0] CMD_CFG_LOAD   = 4'd7;
    localparam logic [3:0] CMD_CHECKSUM   = 4'd8;

    typedef enum logic [1:0] {
        FS_EMPTY   = 2'd0,
        FS_PARTIAL = 2'd1,
        FS_FULL    = 2'd2
    } fill_state_e;

    typedef struct packed {
        logic wr_ok;
        logic rd_ok;
    } host_perm_t;

    // Host access rights for each command code (R7, R8)
    function automatic host_perm_t decode_perm(input logic [3:0] code);
        host_perm_t p;
        p = '{wr_ok: 1'b0, rd_ok: 1'b0};
        case (code)
            CMD_TRANSMIT:   p = '{wr_ok: 1'b1, rd_ok: 1'b0};
            CMD_RECEIVE:    p = '{wr_ok: 1'b0, rd_ok: 1'b1};
            CMD_TRANSCEIVE: p = '{wr_ok: 1'b1, rd_ok: 1'b1};
            CMD_KEY_LOAD,
            CMD_AUTH_STEP1,
            CMD_CFG_LOAD,
            CMD_CHECKSUM:   p = '{wr_ok: 1'b1, rd_ok: 1'b0};
            default:        p = '{wr_ok: 1'b0, rd_ok: 1'b0};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/csf_access_gate.sv
module csf_access_gate #(
    parameter int DATA_W = 8
) (
    input  logic [3:0]        cmd,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_rd,
    input  logic              eng_wr,
    input  logic [DATA_W-1:0] eng_wdata,
    input  logic              eng_rd,
    output logic              push_req,
    output logic [DATA_W-1:0] push_data,
    output logic              pop_req,
    output logic              pop_host,
    output logic              pop_eng
);
    import csf_pkg::*;

    host_perm_t perm;
    logic       host_wr_ok;
    logic       host_rd_ok;

    always_comb begin
        perm       = decode_perm(cmd);
        host_wr_ok = host_wr && perm.wr_ok;
        host_rd_ok = host_rd && perm.rd_ok;
        // engine port wins on both directions (R10)
        push_req   = eng_wr || host_wr_ok;
        push_data  = eng_wr ? eng_wdata : host_wdata;
        pop_eng    = eng_rd;
        pop_host   = host_rd_ok && !eng_rd;
        pop_req    = eng_rd || host_rd_ok;
    end

endmodule

// File: rtl/csf_store.sv
module csf_store #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push_en,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_en,
    output logic [DATA_W-1:0] head_data
);
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push_en) wr_ptr <= wr_ptr + PTR_W'(1);
            if (pop_en)  rd_ptr <= rd_ptr + PTR_W'(1);
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (push_en && !flush && wr_ptr == PTR_W'(g)) begin
                cells[g] <= push_data;
            end
        end
    end

    assign head_data = cells[rd_ptr];

endmodule

// File: rtl/csf_ctrl.sv
module csf_ctrl #(
    parameter int DEPTH = 64,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LEN_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push_req,
    input  logic             pop_req,
    input  logic [PTR_W-1:0] water_level,
    output logic             push_en,
    output logic             pop_en,
    output logic             is_empty,
    output logic [LEN_W-1:0] fill_len,
    output logic             hi_alert,
    output logic             lo_alert,
    output logic             ovfl
);
    import csf_pkg::*;

    localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(DEPTH);
    localparam logic [LEN_W-1:0] NEAR_FULL = LEN_W'(DEPTH - 1);

    fill_state_e      state;
    fill_state_e      state_next;
    logic [LEN_W-1:0] len_next;
    logic [LEN_W-1:0] level_ext;

    always_comb begin
        push_en   = push_req && !flush && (state != FS_FULL);
        pop_en    = pop_req  && !flush && (state != FS_EMPTY);
        is_empty  = (state == FS_EMPTY);
        level_ext = {1'b0, water_level};
        if (flush) begin
            len_next = '0;
        end else begin
            len_next = fill_len + LEN_W'(push_en) - LEN_W'(pop_en);
        end
    end

    // next-state logic with named transitions
    always_comb begin
        state_next = state;
        unique case (state)
            FS_EMPTY: begin
                if (flush)        state_next = FS_EMPTY;
                else if (push_en) state_next = FS_PARTIAL;      // first push
            end
            FS_PARTIAL: begin
                if (flush) begin
                    state_next = FS_EMPTY;
                end else if (push_en && !pop_en && fill_len == NEAR_FULL) begin
                    state_next = FS_FULL;                        // filling push
                end else if (pop_en && !push_en && fill_len == LEN_W'(1)) begin
                    state_next = FS_EMPTY;                       // last pop
                end
            end
            FS_FULL: begin
                if (flush)       state_next = FS_EMPTY;
                else if (pop_en) state_next = FS_PARTIAL;       // draining pop
            end
            default: state_next = FS_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= FS_EMPTY;
            fill_len <= '0;
        end else begin
            state    <= state_next;
            fill_len <= len_next;
        end
    end

    // registered status outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_alert <= 1'b0;
            lo_alert <= 1'b1;
            ovfl     <= 1'b0;
        end else begin
            hi_alert <= (FULL_LEN - len_next) <= level_ext;
            lo_alert <= len_next <= level_ext;
            if (flush) begin
                ovfl <= 1'b0;
            end else if (push_req && state == FS_FULL) begin
                ovfl <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/cmd_shared_fifo.sv
module cmd_shared_fifo #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LEN_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        cmd,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_rd,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              eng_wr,
    input  logic [DATA_W-1:0] eng_wdata,
    input  logic              eng_rd,
    output logic [DATA_W-1:0] eng_rdata,
    input  logic              flush,
    input  logic [PTR_W-1:0]  water_level,
    input  logic              lo_irq_en,
    input  logic              hi_irq_en,
    output logic [LEN_W-1:0]  fill_len,
    output logic              hi_alert,
    output logic              lo_alert,
    output logic              ovfl,
    output logic              irq
);
    logic              push_req;
    logic [DATA_W-1:0] push_data;
    logic              pop_req;
    logic              pop_host;
    logic              pop_eng;
    logic              push_en;
    logic              pop_en;
    logic              is_empty;
    logic [DATA_W-1:0] head_data;
    logic [DATA_W-1:0] read_byte;

    csf_access_gate #(.DATA_W(DATA_W)) u_gate (
        .cmd        (cmd),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .host_rd    (host_rd),
        .eng_wr     (eng_wr),
        .eng_wdata  (eng_wdata),
        .eng_rd     (eng_rd),
        .push_req   (push_req),
        .push_data  (push_data),
        .pop_req    (pop_req),
        .pop_host   (pop_host),
        .pop_eng    (pop_eng)
    );

    csf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush       (flush),
        .push_req    (push_req),
        .pop_req     (pop_req),
        .water_level (water_level),
        .push_en     (push_en),
        .pop_en      (pop_en),
        .is_empty    (is_empty),
        .fill_len    (fill_len),
        .hi_alert    (hi_alert),
        .lo_alert    (lo_alert),
        .ovfl        (ovfl)
    );

    csf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push_en   (push_en),
        .push_data (push_data),
        .pop_en    (pop_en),
        .head_data (head_data)
    );

    // an empty read yields zero (R9)
    assign read_byte = is_empty ? '0 : head_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            host_rdata <= '0;
            eng_rdata  <= '0;
        end else if (!flush) begin
            if (pop_host) host_rdata <= read_byte;
            if (pop_eng)  eng_rdata  <= read_byte;
        end
    end

    assign irq = (lo_irq_en && lo_alert) || (hi_irq_en && hi_alert);

endmodule

// File: rtl/csf_checker.sv
module csf_checker #(
    parameter int DEPTH = 64,
    parameter int DATA_W = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LEN_W = PTR_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        cmd,
    input logic              host_wr,
    input logic              host_rd,
    input logic              eng_wr,
    input logic              eng_rd,
    input logic              flush,
    input logic [PTR_W-1:0]  water_level,
    input logic              lo_irq_en,
    input logic              hi_irq_en,
    input logic [LEN_W-1:0]  fill_len,
    input logic              hi_alert,
    input logic              lo_alert,
    input logic              ovfl,
    input logic              irq,
    input logic [DATA_W-1:0] host_rdata
);
    import csf_pkg::*;

    host_perm_t perm;
    int         free_cnt;
    int         len_int;

    always_comb begin
        perm     = decode_perm(cmd);
        len_int  = int'(fill_len);
        free_cnt = DEPTH - len_int;
    end

    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        len_int <= DEPTH);                                                   // R1
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (fill_len == '0 && !ovfl));                                // R2
    AST_OVFL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovfl && !flush) |=> ovfl);                                          // R3
    AST_OVFL_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (len_int == DEPTH && (eng_wr || (host_wr && perm.wr_ok)) && !flush)
        |=> (ovfl && len_int == DEPTH));                                     // R3
    AST_HI_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        hi_alert == (free_cnt <= int'($past(water_level))));                 // R4
    AST_LO_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        lo_alert == (len_int <= int'($past(water_level))));                  // R5
    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        ((lo_irq_en && lo_alert) || (hi_irq_en && hi_alert)) |-> irq);       // R6
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!(lo_irq_en && lo_alert) && !(hi_irq_en && hi_alert)) |-> !irq);    // R6
    AST_HOST_WR_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !perm.wr_ok && !eng_wr && !eng_rd && !flush
         && !(host_rd && perm.rd_ok)) |=> $stable(fill_len));                // R7
    AST_HOST_RD_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (!(host_rd && perm.rd_ok) || eng_rd) |=> $stable(host_rdata));       // R8
    AST_PAIR_KEEPS_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_wr && eng_rd && !flush && fill_len != '0 && len_int != DEPTH)
        |=> $stable(fill_len));                                              // R9

endmodule

bind cmd_shared_fifo csf_checker #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_csf_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd         (cmd),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .eng_wr      (eng_wr),
    .eng_rd      (eng_rd),
    .flush       (flush),
    .water_level (water_level),
    .lo_irq_en   (lo_irq_en),
    .hi_irq_en   (hi_irq_en),
    .fill_len    (fill_len),
    .hi_alert    (hi_alert),
    .lo_alert    (lo_alert),
    .ovfl        (ovfl),
    .irq         (irq),
    .host_rdata  (host_rdata)
);

// File: tb/test_cmd_shared_fifo.sv
module test_cmd_shared_fifo;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] cmd;
    logic       host_wr, host_rd, eng_wr, eng_rd, flush;
    logic [7:0] host_wdata, eng_wdata;
    logic [7:0] host_rdata, eng_rdata;
    logic [5:0] water_level;
    logic       lo_irq_en, hi_irq_en;
    logic [6:0] fill_len;
    logic       hi_alert, lo_alert, ovfl, irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cmd_shared_fifo i_cmd_shared_fifo (
        .clk(clk), .rst_n(rst_n), .cmd(cmd),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
        .eng_wr(eng_wr), .eng_wdata(eng_wdata), .eng_rd(eng_rd), .eng_rdata(eng_rdata),
        .flush(flush), .water_level(water_level), .lo_irq_en(lo_irq_en), .hi_irq_en(hi_irq_en),
        .fill_len(fill_len), .hi_alert(hi_alert), .lo_alert(lo_alert), .ovfl(ovfl), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic eng_push(input logic [7:0] d);
        eng_wr = 1'b1; eng_wdata = d; tick(); eng_wr = 1'b0;
    endtask

    task automatic eng_pop();
        eng_rd = 1'b1; tick(); eng_rd = 1'b0;
    endtask

    task automatic host_push(input logic [7:0] d);
        host_wr = 1'b1; host_wdata = d; tick(); host_wr = 1'b0;
    endtask

    task automatic host_pop();
        host_rd = 1'b1; tick(); host_rd = 1'b0;
    endtask

    task automatic do_flush();
        flush = 1'b1; tick(); flush = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11 fill_len", fill_len, 0);
        chk("R11 lo_alert", lo_alert, 1);
        chk("R11 hi_alert", hi_alert, 0);
        chk("R11 ovfl", ovfl, 0);
        chk("R11 host_rdata", host_rdata, 0);
        chk("R11 eng_rdata", eng_rdata, 0);
    endtask

    task automatic t_host_gating();
        cmd = 4'd1; host_push(8'h01);
        chk("R7 idle write refused", fill_len, 0);
        cmd = 4'd0; host_push(8'h02);
        chk("R7 startup write refused", fill_len, 0);
        cmd = 4'd3; host_push(8'h03);
        chk("R7 receive write refused", fill_len, 0);
        cmd = 4'd2; host_push(8'hA1); host_push(8'hA2);
        chk("R7 transmit writes", fill_len, 2);
        cmd = 4'd4; host_push(8'hA3);
        chk("R7 transceive write", fill_len, 3);
        cmd = 4'd2; host_pop();
        chk("R7 transmit read refused len", fill_len, 3);
        chk("R7 transmit read refused data", host_rdata, 0);
        cmd = 4'd3; host_pop();
        chk("R7 receive read data", host_rdata, 8'hA1);
        chk("R7 receive read len", fill_len, 2);
        cmd = 4'd4; host_pop();
        chk("R7 transceive read data", host_rdata, 8'hA2);
        cmd = 4'd1; host_pop();
        chk("R7 idle read refused len", fill_len, 1);
        chk("R7 idle read refused data", host_rdata, 8'hA2);
    endtask

    task automatic t_arg_cmds();
        cmd = 4'd5; host_push(8'hB1);
        cmd = 4'd6; host_push(8'hB2);
        cmd = 4'd7; host_push(8'hB3);
        cmd = 4'd8; host_push(8'hB4);
        chk("R8 argument writes", fill_len, 5);
        host_pop();
        chk("R8 checksum read refused len", fill_len, 5);
        chk("R8 checksum read refused data", host_rdata, 8'hA2);
        cmd = 4'd12; host_push(8'hEE); host_pop();
        chk("R8 unknown code refused", fill_len, 5);
        cmd = 4'd3; host_pop();
        chk("R1 order first", host_rdata, 8'hA3);
        host_pop();
        chk("R1 order second", host_rdata, 8'hB1);
    endtask

    task automatic t_flush_empty();
        do_flush();
        chk("R2 flush len", fill_len, 0);
        cmd = 4'd3; host_pop();
        chk("R9 empty read zero", host_rdata, 0);
        chk("R9 empty read len", fill_len, 0);
        flush = 1'b1; eng_wr = 1'b1; eng_wdata = 8'h99; tick();
        flush = 1'b0; eng_wr = 1'b0;
        chk("R2 flush beats write", fill_len, 0);
        eng_push(8'h5A); eng_pop();
        chk("R9 pointers kept after empty read", eng_rdata, 8'h5A);
    endtask

    task automatic t_fill_overflow();
        do_flush();
        water_level = 6'd0;
        for (int i = 0; i < 64; i++) eng_push(8'(i));
        chk("R1 full count", fill_len, 64);
        chk("R4 full hi_alert", hi_alert, 1);
        chk("R3 no ovfl yet", ovfl, 0);
        eng_push(8'hAA);
        chk("R3 ovfl set", ovfl, 1);
        chk("R3 len kept", fill_len, 64);
        eng_pop();
        chk("R3 head intact", eng_rdata, 0);
        for (int i = 0; i < 62; i++) eng_pop();
        eng_pop();
        chk("R3 tail intact", eng_rdata, 63);
        chk("R1 drained", fill_len, 0);
        chk("R3 ovfl sticky", ovfl, 1);
        do_flush();
        chk("R3 flush clears ovfl", ovfl, 0);
    endtask

    task automatic t_thresholds();
        water_level = 6'd10;
        do_flush();
        for (int i = 1; i <= 54; i++) begin
            eng_push(8'(i));
            if (i == 10) chk("R5 lo at level", lo_alert, 1);
            if (i == 11) chk("R5 lo above level", lo_alert, 0);
            if (i == 53) chk("R4 hi free 11", hi_alert, 0);
            if (i == 54) chk("R4 hi free 10", hi_alert, 1);
        end
        water_level = 6'd9; tick();
        chk("R4 lower level drops hi", hi_alert, 0);
        water_level = 6'd10; tick();
        chk("R4 level restored", hi_alert, 1);
    endtask

    task automatic t_irq();
        hi_irq_en = 1'b1; #1;
        chk("R6 hi irq", irq, 1);
        hi_irq_en = 1'b0; lo_irq_en = 1'b1; #1;
        chk("R6 lo masked source idle", irq, 0);
        do_flush();
        chk("R6 lo irq", irq, 1);
        lo_irq_en = 1'b0; #1;
        chk("R6 irq masked", irq, 0);
    endtask

    task automatic t_simultaneous();
        do_flush();
        for (int i = 0; i < 5; i++) eng_push(8'(8'h10 + i));
        eng_wr = 1'b1; eng_wdata = 8'h77; eng_rd = 1'b1; tick();
        eng_wr = 1'b0; eng_rd = 1'b0;
        chk("R9 push pop len", fill_len, 5);
        chk("R9 push pop data", eng_rdata, 8'h10);
        eng_pop();
        chk("R9 next head", eng_rdata, 8'h11);
    endtask

    task automatic t_priority();
        logic [7:0] prev;
        do_flush();
        cmd = 4'd2;
        host_wr = 1'b1; host_wdata = 8'h11; eng_wr = 1'b1; eng_wdata = 8'h22; tick();
        host_wr = 1'b0; eng_wr = 1'b0;
        chk("R10 one write kept", fill_len, 1);
        cmd = 4'd3;
        prev = host_rdata;
        host_rd = 1'b1; eng_rd = 1'b1; tick();
        host_rd = 1'b0; eng_rd = 1'b0;
        chk("R10 engine write won", eng_rdata, 8'h22);
        chk("R10 host read dropped", host_rdata, prev);
        chk("R10 drained", fill_len, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cmd = 4'd1; flush = 1'b0;
        host_wr = 1'b0; host_rd = 1'b0; eng_wr = 1'b0; eng_rd = 1'b0;
        host_wdata = '0; eng_wdata = '0; water_level = 6'd4;
        lo_irq_en = 1'b0; hi_irq_en = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_host_gating();
        t_arg_cmds();
        t_flush_empty();
        t_fill_overflow();
        t_thresholds();
        t_irq();
        t_simultaneous();
        t_priority();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule